// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of an Ethernet receive DMA. Software builds a ring of receive descriptors in a small on-block descriptor store. Each entry holds a 16-bit status word, a 16-bit length word and a 32-bit buffer pointer. Software arms an entry by setting its EMPTY bit. When a frame starts, the engine looks at the descriptor at its current index. If that descriptor is armed, the engine issues a one-cycle buffer-write strobe carrying the descriptor's buffer pointer; this strobe stands in for the payload transfer. When the frame ends, the engine writes the length and the error flags back into the descriptor, clears EMPTY and moves on.

The ring has no fixed depth. It closes at whichever descriptor carries the WRAP bit, and after that descriptor the engine goes back to the programmed ring base. If a frame arrives while the current descriptor still belongs to software, the engine raises a busy event and halts. It stays halted until software issues the clear-halt command. A graceful stop request lets any frame in progress finish, then parks the engine and raises a stop-complete event. All events are write-one-to-clear.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the event register (address 3), the ring base (address 0), the stop control (address 1) and the command register (address 2) all read as zero, and no buffer strobe is active.
- R2: When a frame starts and the current descriptor has EMPTY (status bit 15) set, `buf_wr_en` is high for exactly the one cycle after the start, and `buf_ptr` carries that descriptor's pointer.
- R3: When the frame ends, the descriptor is written in a single cycle. Its status keeps all bits except 15 and 3:0. Bit 15 (EMPTY) is cleared and bits 3:0 take `frm_err`. Its length takes `frm_len` unchanged; that value includes the 4-byte FCS.
- R4: After a descriptor without WRAP (status bit 13), the index advances by one. After a descriptor with WRAP, the index returns to the ring base.
- R5: A frame start that finds EMPTY clear sets event bit 0 (busy), produces no strobe and halts reception. While halted, frame starts produce no strobe and no descriptor is modified.
- R6: Writing 1 to bit 0 of the command register (address 2) leaves the halt. The next frame uses the same descriptor index that caused the halt.
- R7: Setting bit 0 of the control register (address 1) requests a graceful stop. A frame in progress completes and is written back, then event bit 1 (stop complete) is set. Frames are ignored while stopped. Clearing the bit resumes reception.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R9: Writing the ring base (address 0) moves the index to that base. A later WRAP returns the engine to that base, not to entry 0.
- R10: Every completed frame sets event bit 2 (frame stored).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Pulse: a frame begins |
| frm_end | input | 1 | Pulse: the frame ends; length and flags valid |
| frm_len | input | 16 | Frame byte count including FCS |
| frm_err | input | 4 | Receive error flags of the frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 base, 1 control, 2 command, 3 events) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` |
| dsc_we | input | 1 | Software descriptor write strobe |
| dsc_idx | input | IDX_W | Descriptor entry for software read and write |
| dsc_sel | input | 2 | Field select: 0 status, 1 length, 2 pointer |
| dsc_wdata | input | 32 | Software descriptor write data |
| dsc_status | output | 16 | Status word of entry `dsc_idx` |
| dsc_len | output | 16 | Length word of entry `dsc_idx` |
| dsc_ptr | output | 32 | Buffer pointer of entry `dsc_idx` |
| buf_wr_en | output | 1 | Buffer-write strobe for an accepted frame |
| buf_ptr | output | 32 | Buffer pointer of the accepted descriptor |

## Verification
The main walk sends frames of different lengths and error patterns around a four-entry ring whose last entry carries WRAP. The order of the buffer pointers separates index stepping from wrapping. The written-back status separates cleared EMPTY, preserved bits and error flags. Separate runs arm a descriptor as software-owned, hold the stop request across a frame, and move the ring base. These show that the busy halt, the graceful stop and the base-relative wrap each behave differently from normal reception.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ERR_W    = 4;

  localparam logic [1:0] RA_BASE  = 2'd0;
  localparam logic [1:0] RA_CTRL  = 2'd1;
  localparam logic [1:0] RA_CMD   = 2'd2;
  localparam logic [1:0] RA_EVENT = 2'd3;

  localparam int EV_BUSY  = 0;
  localparam int EV_STOP  = 1;
  localparam int EV_FRAME = 2;
  localparam int EV_W     = 3;

  localparam logic [1:0] F_STATUS = 2'd0;
  localparam logic [1:0] F_LEN    = 2'd1;
  localparam logic [1:0] F_PTR    = 2'd2;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RECV = 2'd1,
    S_HALT = 2'd2,
    S_STOP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_ring_mem.sv
module rx_ring_mem
  import rx_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [1:0]       sw_sel,
  input  logic [31:0]      sw_wdata,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [15:0]      wb_status,
  input  logic [15:0]      wb_len,
  input  logic [IDX_W-1:0] eng_idx,
  output logic [15:0]      eng_status,
  output logic [31:0]      eng_ptr,
  output logic [15:0]      sw_status,
  output logic [15:0]      sw_len,
  output logic [31:0]      sw_ptr
);
  logic [15:0] status_q [DEPTH];
  logic [15:0] len_q    [DEPTH];
  logic [31:0] ptr_q    [DEPTH];

  logic [DEPTH-1:0] st_we, ln_we, pt_we;
  logic [15:0] st_d [DEPTH];
  logic [15:0] ln_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic hit_wb, hit_sw;
      hit_wb = wb_en && (wb_idx == IDX_W'(i));
      hit_sw = sw_we && (sw_idx == IDX_W'(i));
      st_we[i] = hit_wb || (hit_sw && sw_sel == F_STATUS);
      ln_we[i] = hit_wb || (hit_sw && sw_sel == F_LEN);
      pt_we[i] = hit_sw && sw_sel == F_PTR;
      st_d[i]  = hit_wb ? wb_status : sw_wdata[15:0];
      ln_d[i]  = hit_wb ? wb_len    : sw_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        status_q[i] <= '0;
        len_q[i]    <= '0;
        ptr_q[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (st_we[i]) status_q[i] <= st_d[i];
        if (ln_we[i]) len_q[i]    <= ln_d[i];
        if (pt_we[i]) ptr_q[i]    <= sw_wdata;
      end
    end
  end

  assign eng_status = status_q[eng_idx];
  assign eng_ptr    = ptr_q[eng_idx];
  assign sw_status  = status_q[sw_idx];
  assign sw_len     = len_q[sw_idx];
  assign sw_ptr     = ptr_q[sw_idx];
endmodule

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [EV_W-1:0]  ev_set,
  output logic [IDX_W-1:0] base,
  output logic             base_wr,
  output logic [IDX_W-1:0] base_new,
  output logic             gstop,
  output logic             halt_clr,
  output logic [EV_W-1:0]  events,
  output logic [31:0]      reg_rdata
);
  logic [IDX_W-1:0] base_q, base_d;
  logic             gstop_q, gstop_d;
  logic [EV_W-1:0]  ev_q, ev_d;
  logic             ctrl_wr, ev_wr;

  assign base_wr  = reg_wr && reg_addr == RA_BASE;
  assign ctrl_wr  = reg_wr && reg_addr == RA_CTRL;
  assign ev_wr    = reg_wr && reg_addr == RA_EVENT;
  assign halt_clr = reg_wr && reg_addr == RA_CMD && reg_wdata[0];
  assign base_new = reg_wdata[IDX_W-1:0];

  always_comb begin
    base_d  = base_wr ? base_new : base_q;
    gstop_d = ctrl_wr ? reg_wdata[0] : gstop_q;
    ev_d    = ev_q;
    if (ev_wr) ev_d = ev_d & ~reg_wdata[EV_W-1:0];
    ev_d = ev_d | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      gstop_q <= 1'b0;
      ev_q    <= '0;
    end else begin
      base_q  <= base_d;
      gstop_q <= gstop_d;
      ev_q    <= ev_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_BASE:  reg_rdata = 32'(base_q);
      RA_CTRL:  reg_rdata = {31'b0, gstop_q};
      RA_EVENT: reg_rdata = 32'(ev_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign base   = base_q;
  assign gstop  = gstop_q;
  assign events = ev_q;
endmodule

// File: rtl/rx_ring_fsm.sv
module rx_ring_fsm
  import rx_ring_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic [15:0]      frm_len,
  input  logic [ERR_W-1:0] frm_err,
  input  logic [15:0]      cur_status,
  input  logic [31:0]      cur_ptr,
  input  logic [IDX_W-1:0] base,
  input  logic             base_wr,
  input  logic [IDX_W-1:0] base_new,
  input  logic             gstop,
  input  logic             halt_clr,
  output logic [IDX_W-1:0] idx,
  output logic             wb_en,
  output logic [15:0]      wb_status,
  output logic [15:0]      wb_len,
  output logic             buf_wr_en,
  output logic [31:0]      buf_ptr,
  output logic [EV_W-1:0]  ev_set,
  output rx_state_e        state
);
  localparam logic [15:0] CLR_MASK =
    ~((16'd1 << ST_EMPTY) | 16'((1 << ERR_W) - 1));

  rx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             strb_q, strb_d;
  logic [31:0]      ptr_q, ptr_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    strb_d  = 1'b0;
    ptr_d   = ptr_q;
    wb_en   = 1'b0;
    ev_set  = '0;
    case (state_q)
      S_IDLE: begin
        if (gstop) begin
          state_d         = S_STOP;
          ev_set[EV_STOP] = 1'b1;
        end else if (frm_start) begin
          if (cur_status[ST_EMPTY]) begin
            state_d = S_RECV;
            strb_d  = 1'b1;
            ptr_d   = cur_ptr;
          end else begin
            state_d         = S_HALT;
            ev_set[EV_BUSY] = 1'b1;
          end
        end
      end
      S_RECV: begin
        if (frm_end) begin
          wb_en            = 1'b1;
          ev_set[EV_FRAME] = 1'b1;
          idx_d = cur_status[ST_WRAP] ? base : idx_q + 1'b1;
          if (gstop) begin
            state_d         = S_STOP;
            ev_set[EV_STOP] = 1'b1;
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      S_HALT: if (halt_clr) state_d = S_IDLE;
      S_STOP: if (!gstop)   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (base_wr) idx_d = base_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      strb_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      strb_q  <= strb_d;
      ptr_q   <= ptr_d;
    end
  end

  assign wb_status = (cur_status & CLR_MASK) | 16'(frm_err);
  assign wb_len    = frm_len;
  assign idx       = idx_q;
  assign buf_wr_en = strb_q;
  assign buf_ptr   = ptr_q;
  assign state     = state_q;
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic [15:0]      frm_len,
  input  logic [3:0]       frm_err,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dsc_we,
  input  logic [IDX_W-1:0] dsc_idx,
  input  logic [1:0]       dsc_sel,
  input  logic [31:0]      dsc_wdata,
  output logic [15:0]      dsc_status,
  output logic [15:0]      dsc_len,
  output logic [31:0]      dsc_ptr,
  output logic             buf_wr_en,
  output logic [31:0]      buf_ptr
);
  logic [IDX_W-1:0] base, base_new, idx;
  logic             base_wr, gstop, halt_clr, wb_en;
  logic [15:0]      wb_status, wb_len, cur_status;
  logic [31:0]      cur_ptr;
  logic [EV_W-1:0]  ev_set, events;
  rx_state_e        eng_state;

  rx_ring_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .sw_we(dsc_we), .sw_idx(dsc_idx), .sw_sel(dsc_sel), .sw_wdata(dsc_wdata),
    .wb_en(wb_en), .wb_idx(idx), .wb_status(wb_status), .wb_len(wb_len),
    .eng_idx(idx), .eng_status(cur_status), .eng_ptr(cur_ptr),
    .sw_status(dsc_status), .sw_len(dsc_len), .sw_ptr(dsc_ptr)
  );

  rx_ring_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ev_set(ev_set), .base(base), .base_wr(base_wr), .base_new(base_new),
    .gstop(gstop), .halt_clr(halt_clr), .events(events), .reg_rdata(reg_rdata)
  );

  rx_ring_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .frm_start(frm_start), .frm_end(frm_end), .frm_len(frm_len), .frm_err(frm_err),
    .cur_status(cur_status), .cur_ptr(cur_ptr),
    .base(base), .base_wr(base_wr), .base_new(base_new),
    .gstop(gstop), .halt_clr(halt_clr),
    .idx(idx), .wb_en(wb_en), .wb_status(wb_status), .wb_len(wb_len),
    .buf_wr_en(buf_wr_en), .buf_ptr(buf_ptr), .ev_set(ev_set), .state(eng_state)
  );
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk
  import rx_ring_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state,
  input logic [IDX_W-1:0] idx,
  input logic [IDX_W-1:0] base,
  input logic             base_wr,
  input logic [15:0]      cur_status,
  input logic             wb_en,
  input logic             buf_wr_en,
  input logic             frm_start,
  input logic             gstop,
  input logic             halt_clr,
  input logic [EV_W-1:0]  events
);
  // R5
  busy_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !gstop && frm_start && !cur_status[ST_EMPTY])
      |=> (state == S_HALT && events[EV_BUSY]));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HALT && !halt_clr) |=> state == S_HALT);

  // R2
  strobe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> $past(cur_status[ST_EMPTY]));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> !buf_wr_en);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && cur_status[ST_WRAP] && !base_wr) |=> idx == base);

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !cur_status[ST_WRAP] && !base_wr)
      |=> idx == IDX_W'($past(idx) + 1'b1));

  // R7
  stop_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && $past(state) != S_STOP) |-> events[EV_STOP]);
endmodule

bind rx_ring_dma rx_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(eng_state), .idx(idx), .base(base),
  .base_wr(base_wr), .cur_status(cur_status), .wb_en(wb_en),
  .buf_wr_en(buf_wr_en), .frm_start(frm_start), .gstop(gstop),
  .halt_clr(halt_clr), .events(events)
);

// File: tb/sim_rx_ring_dma.sv
module sim_rx_ring_dma;
  localparam int DEPTH = 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [15:0] ARM   = 16'h8040;
  localparam logic [15:0] ARM_W = 16'hA040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 0, frm_end = 0, reg_wr = 0, dsc_we = 0;
  logic [15:0] frm_len = 0;
  logic [3:0]  frm_err = 0;
  logic [1:0]  reg_addr = 0, dsc_sel = 0;
  logic [31:0] reg_wdata = 0, dsc_wdata = 0;
  logic [IDX_W-1:0] dsc_idx = 0;
  logic [31:0] reg_rdata, dsc_ptr, buf_ptr;
  logic [15:0] dsc_status, dsc_len;
  logic buf_wr_en;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_ring_dma #(.DEPTH(DEPTH)) u0 (.*);

  // {len, err, expected descriptor index}
  localparam logic [22:0] VEC [6] = '{
    {16'd64,   4'h0, 3'd0},
    {16'd1518, 4'h0, 3'd1},
    {16'd72,   4'h1, 3'd2},
    {16'd90,   4'hA, 3'd3},
    {16'd60,   4'h0, 3'd0},
    {16'd1522, 4'hF, 3'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic dsc_write(input int i, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); dsc_we = 1; dsc_idx = IDX_W'(i); dsc_sel = s; dsc_wdata = d;
    @(negedge clk); dsc_we = 0;
  endtask

  task automatic dsc_read(input int i, output logic [15:0] st, output logic [15:0] ln);
    @(negedge clk); dsc_idx = IDX_W'(i); #1 st = dsc_status; ln = dsc_len;
  endtask

  task automatic f_start(output logic s, output logic [31:0] p);
    @(negedge clk); frm_start = 1;
    @(negedge clk); frm_start = 0; s = buf_wr_en; p = buf_ptr;
    @(negedge clk);
    if (buf_wr_en) begin checks++; errors++; $display("FAIL R2 strobe longer than one cycle actual=1 expected=0"); end
  endtask

  task automatic f_end(input logic [15:0] l, input logic [3:0] e);
    @(negedge clk); frm_end = 1; frm_len = l; frm_err = e;
    @(negedge clk); frm_end = 0;
  endtask

  function automatic logic [31:0] ptr_of(input int i);
    return 32'h1000_0000 + 32'(i) * 32'h100;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, p;
    logic [15:0] st, ln;
    logic s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), r);
      chk(r == 0, "R1 register reset", r, 0);
    end
    chk(buf_wr_en == 0, "R1 strobe idle", 32'(buf_wr_en), 0);

    // ring of four, WRAP on entry 3
    for (int i = 0; i < 4; i++) begin
      dsc_write(i, 2'd2, ptr_of(i));
      dsc_write(i, 2'd0, 32'(i == 3 ? ARM_W : ARM));
    end

    // table walk: R2 R3 R4 R10 R8
    for (int v = 0; v < 6; v++) begin
      logic [15:0] l; logic [3:0] e; int di; logic [15:0] init;
      l = VEC[v][22:7]; e = VEC[v][6:3]; di = int'(VEC[v][2:0]);
      init = (di == 3) ? ARM_W : ARM;
      f_start(s, p);
      chk(s == 1, "R2 strobe on armed descriptor", 32'(s), 1);
      chk(p == ptr_of(di), "R2/R4 pointer of expected descriptor", p, ptr_of(di));
      f_end(l, e);
      dsc_read(di, st, ln);
      chk(st == ((init & 16'h7FF0) | 16'(e)), "R3 written status", 32'(st), 32'((init & 16'h7FF0) | 16'(e)));
      chk(ln == l, "R3 written length incl FCS", 32'(ln), 32'(l));
      reg_read(2'd3, r);
      chk(r == 32'h4, "R10 frame event", r, 32'h4);
      reg_write(2'd3, 32'h4);
      reg_read(2'd3, r);
      chk(r == 0, "R8 W1C clears frame event", r, 0);
      dsc_write(di, 2'd0, 32'(init));
    end

    // R5 busy: next index is 2; hand it to software
    dsc_write(2, 2'd0, 32'h0040);
    f_start(s, p);
    chk(s == 0, "R5 no strobe on owned descriptor", 32'(s), 0);
    f_end(16'd100, 4'h0);
    reg_read(2'd3, r);
    chk(r == 32'h1, "R5 busy event only", r, 32'h1);
    dsc_read(2, st, ln);
    chk(st == 16'h0040, "R5 descriptor untouched", 32'(st), 32'h0040);
    reg_write(2'd3, 32'h0);
    reg_read(2'd3, r);
    chk(r == 32'h1, "R8 write zero keeps event", r, 32'h1);
    reg_write(2'd3, 32'h1);
    dsc_write(2, 2'd0, 32'(ARM));
    f_start(s, p);
    chk(s == 0, "R5 halted ignores frame", 32'(s), 0);
    f_end(16'd100, 4'h0);
    dsc_read(2, st, ln);
    chk(st == ARM, "R5 halted leaves descriptor", 32'(st), 32'(ARM));
    reg_write(2'd2, 32'h1);
    f_start(s, p);
    chk(s == 1 && p == ptr_of(2), "R6 resume at same index", p, ptr_of(2));
    f_end(16'd128, 4'h0);
    dsc_read(2, st, ln);
    chk(st == 16'h0040 && ln == 16'd128, "R6 frame stored after resume", {st, ln}, {16'h0040, 16'd128});
    dsc_write(2, 2'd0, 32'(ARM));
    reg_write(2'd3, 32'h7);

    // R7 graceful stop during a frame on entry 3
    f_start(s, p);
    chk(s == 1 && p == ptr_of(3), "R7 frame before stop", p, ptr_of(3));
    reg_write(2'd1, 32'h1);
    f_end(16'd200, 4'h2);
    dsc_read(3, st, ln);
    chk(st == 16'h2042 && ln == 16'd200, "R7 in-progress frame completed", {st, ln}, {16'h2042, 16'd200});
    reg_read(2'd3, r);
    chk(r == 32'h6, "R7 stop-complete event", r, 32'h6);
    f_start(s, p);
    chk(s == 0, "R7 stopped ignores frame", 32'(s), 0);
    f_end(16'd70, 4'h0);
    dsc_read(0, st, ln);
    chk(st == ARM, "R7 stopped leaves descriptor", 32'(st), 32'(ARM));
    reg_write(2'd1, 32'h0);
    reg_write(2'd3, 32'h7);
    f_start(s, p);
    chk(s == 1 && p == ptr_of(0), "R7/R4 resume after wrap at entry 0", p, ptr_of(0));
    f_end(16'd66, 4'h0);

    // R9 base move
    dsc_write(4, 2'd2, ptr_of(4));
    dsc_write(4, 2'd0, 32'(ARM));
    dsc_write(5, 2'd2, ptr_of(5));
    dsc_write(5, 2'd0, 32'(ARM_W));
    reg_write(2'd0, 32'h4);
    reg_read(2'd0, r);
    chk(r == 32'h4, "R9 base readback", r, 32'h4);
    f_start(s, p);
    chk(s == 1 && p == ptr_of(4), "R9 index moved to base", p, ptr_of(4));
    f_end(16'd64, 4'h0);
    dsc_write(4, 2'd0, 32'(ARM));
    f_start(s, p);
    chk(p == ptr_of(5), "R9 step within moved ring", p, ptr_of(5));
    f_end(16'd64, 4'h0);
    f_start(s, p);
    chk(s == 1 && p == ptr_of(4), "R9 wrap returns to base", p, ptr_of(4));
    f_end(16'd64, 4'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule